// File: doc/BRIEF.md
# Descriptor-Chained Single-Channel DMA Engine

This block is one DMA channel that moves a transfer made of several blocks, each described by a four-word record held in memory. Software writes a start pointer and a destination address, turns on the global enable and then the channel enable. The channel reads the first record, moves that record's block word by word through a simple memory master, and follows the record's link to the next one. The source address of every block comes from its record. The destination address is not reloaded between blocks: it keeps running from where the previous block left off. The destination word in each record is read but has no effect.

Either side of a block can be marked as a peripheral. A peripheral side waits for permission before each word. That permission comes either from a hardware request line or from a software request register, and the hardware line is answered with an acknowledge pulse. A memory side never waits. Raw status flags record block completion, chain completion, errors and per-side transactions. Software clears them by writing ones to a clear register.

Top module: `dma_llist_chan`

## Requirements
- R1: After reset the channel enable reads 0, the raw status reads 0, the destination register reads 0 and `mem_req` is low.
- R2: The channel starts only when bit 0 of register 0 (global enable) is 1 and a 1 is written to bit 0 of register 1 (channel enable). A write to register 1 while the global enable is 0 is ignored and issues no memory request.
- R3: A record at pointer P is read as four words: source at P, destination at P+4, link at P+8, control at P+12. The first record is read from the start pointer (register 2) before any data word moves.
- R4: The destination word of a record has no effect. Data goes to the address in the destination register (register 3), and that register carries on unchanged from one block to the next.
- R5: A nonzero link starts a fetch of the record at that address. A zero link ends the transfer after its block. At the end, the channel enable clears itself and status bit 1 (transfer done) sets. Status bit 0 (block done) sets as each block finishes.
- R6: Control word bits [15:0] give the block length in words. A length of 0 moves no data but still counts as a finished block. Bits [17:16] set the source address mode and bits [19:18] set the destination address mode: 0 steps up by 4, 1 steps down by 4, and 2 or 3 keeps the address fixed.
- R7: Control bit 20 marks the source as a peripheral and bit 21 marks the destination as a peripheral. For a peripheral side, register 4 selects how it is paced: bit 0 for the source and bit 1 for the destination, where 0 means hardware and 1 means software. In hardware mode that side waits for its request input before each word and pulses its acknowledge for one cycle after the word's memory response. A memory side never waits.
- R8: In software mode, each write of a 1 to register 7 (bit 0 for the source, bit 1 for the destination) allows exactly one word on that side, and no acknowledge pulse is given.
- R9: Status bit 3 sets when a source peripheral word completes and bit 4 when a destination peripheral word completes. Writing ones to register 6 clears the matching status bits. Status is read from register 5.
- R10: A memory response with `mem_err` set raises status bit 2, stops the channel with `mem_req` low and clears the channel enable. Transfer done is not set.
- R11: Once raised, `mem_req` and its address, write flag and write data stay stable until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | W | Register write data |
| reg_rdata | output | W | Register read data, combinational |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | W | Memory byte address |
| mem_wdata | output | W | Memory write data |
| mem_rdata | input | W | Memory read data, valid with `mem_ack` |
| mem_ack | input | 1 | Memory response for the pending request |
| mem_err | input | 1 | Response is an error, valid with `mem_ack` |
| src_hreq | input | 1 | Source peripheral hardware request |
| src_hack | output | 1 | Source peripheral acknowledge pulse |
| dst_hreq | input | 1 | Destination peripheral hardware request |
| dst_hack | output | 1 | Destination peripheral acknowledge pulse |

## Verification
The bound checker watches, on every cycle, that memory requests stay steady until answered, that the channel never becomes enabled without the global enable, that no request is issued while the channel is off, that the done and error flags only rise together with the enable dropping, and that each acknowledge pulse follows a memory response in the right direction. What only the bench scenarios can show is the data side. It sweeps chain length, block length and both address modes, and compares the whole destination memory image and the final destination address against arithmetic that ignores each record's destination word. It also shows that hardware and software pacing hold the channel until permission arrives.

// File: rtl/dma_llist_chan.sv
module dma_llist_chan #(
  parameter int W    = 32,
  parameter int LENW = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_we,
  input  logic [2:0]   reg_addr,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  output logic         mem_req,
  output logic         mem_we,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  input  logic [W-1:0] mem_rdata,
  input  logic         mem_ack,
  input  logic         mem_err,
  input  logic         src_hreq,
  output logic         src_hack,
  input  logic         dst_hreq,
  output logic         dst_hack
);
  localparam int STEP = W / 8;
  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_XFER, S_NEXT} st_t;

  st_t            st;
  logic           gen, chen, phase_wr, issued;
  logic [1:0]     idx, hs_sw, sw_pend, smode, dmode;
  logic           sper, dper;
  logic [W-1:0]   start_ptr, dar, sar, llp, cur, buf_q;
  logic [LENW-1:0] left;
  logic [4:0]     raw, raw_set, raw_clr;
  logic [1:0]     sw_clr;

  function automatic logic [W-1:0] step(input logic [W-1:0] a, input logic [1:0] m);
    case (m)
      2'd0:    step = a + W'(STEP);
      2'd1:    step = a - W'(STEP);
      default: step = a;
    endcase
  endfunction

  wire src_ok = !sper || (hs_sw[0] ? sw_pend[0] : src_hreq);
  wire dst_ok = !dper || (hs_sw[1] ? sw_pend[1] : dst_hreq);
  wire xfer_rd = (st == S_XFER) && !phase_wr;
  wire xfer_wr = (st == S_XFER) && phase_wr;

  assign mem_req   = (st == S_FETCH) || (xfer_rd && (src_ok || issued)) ||
                     (xfer_wr && (dst_ok || issued));
  assign mem_we    = xfer_wr;
  assign mem_addr  = (st == S_FETCH) ? cur + W'({idx, 2'b00}) : (xfer_wr ? dar : sar);
  assign mem_wdata = buf_q;

  wire resp    = mem_req && mem_ack;
  wire ok_resp = resp && !mem_err;
  wire rd_done = ok_resp && xfer_rd;
  wire wr_done = ok_resp && xfer_wr;
  wire start   = reg_we && reg_addr == 3'd1 && reg_wdata[0] && gen && st == S_IDLE;

  always_comb begin
    raw_set = '0;
    raw_set[0] = (st == S_NEXT);
    raw_set[1] = (st == S_NEXT) && llp == '0;
    raw_set[2] = resp && mem_err;
    raw_set[3] = rd_done && sper;
    raw_set[4] = wr_done && dper;
    raw_clr = (reg_we && reg_addr == 3'd6) ? reg_wdata[4:0] : 5'd0;
    sw_clr  = {wr_done && dper && hs_sw[1], rd_done && sper && hs_sw[0]};
  end

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = W'(gen);
      3'd1:    reg_rdata = W'(chen);
      3'd2:    reg_rdata = start_ptr;
      3'd3:    reg_rdata = dar;
      3'd4:    reg_rdata = W'(hs_sw);
      3'd5:    reg_rdata = W'(raw);
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; gen <= 1'b0; chen <= 1'b0; phase_wr <= 1'b0; issued <= 1'b0;
      idx <= '0; hs_sw <= '0; sw_pend <= '0; smode <= '0; dmode <= '0;
      sper <= 1'b0; dper <= 1'b0; start_ptr <= '0; dar <= '0; sar <= '0;
      llp <= '0; cur <= '0; buf_q <= '0; left <= '0; raw <= '0;
      src_hack <= 1'b0; dst_hack <= 1'b0;
    end else begin
      raw      <= (raw & ~raw_clr) | raw_set;
      sw_pend  <= (sw_pend | ((reg_we && reg_addr == 3'd7) ? reg_wdata[1:0] : 2'b00)) & ~sw_clr;
      issued   <= mem_req && !mem_ack;
      src_hack <= rd_done && sper && !hs_sw[0];
      dst_hack <= wr_done && dper && !hs_sw[1];
      if (reg_we) begin
        case (reg_addr)
          3'd0: gen <= reg_wdata[0];
          3'd2: start_ptr <= reg_wdata;
          3'd3: if (st == S_IDLE) dar <= reg_wdata;
          3'd4: hs_sw <= reg_wdata[1:0];
          default: ;
        endcase
      end
      if (start) begin
        chen <= 1'b1; cur <= start_ptr; idx <= '0; st <= S_FETCH;
      end
      if (resp && mem_err) begin
        st <= S_IDLE; chen <= 1'b0;
      end else if (ok_resp && st == S_FETCH) begin
        idx <= idx + 2'd1;
        case (idx)
          2'd0: sar <= mem_rdata;
          2'd2: llp <= mem_rdata;
          2'd3: begin
            left <= mem_rdata[LENW-1:0];
            smode <= mem_rdata[17:16]; dmode <= mem_rdata[19:18];
            sper <= mem_rdata[20]; dper <= mem_rdata[21];
            phase_wr <= 1'b0;
            st <= (mem_rdata[LENW-1:0] == '0) ? S_NEXT : S_XFER;
          end
          default: ;
        endcase
      end else if (rd_done) begin
        buf_q <= mem_rdata; sar <= step(sar, smode); phase_wr <= 1'b1;
      end else if (wr_done) begin
        dar <= step(dar, dmode); left <= left - 1'b1; phase_wr <= 1'b0;
        if (left == LENW'(1)) st <= S_NEXT;
      end else if (st == S_NEXT) begin
        if (llp != '0) begin
          cur <= llp; idx <= '0; st <= S_FETCH;
        end else begin
          chen <= 1'b0; st <= S_IDLE;
        end
      end
    end
  end
endmodule

module dma_llist_chan_chk #(parameter int W = 32) (
  input logic         clk,
  input logic         rst_n,
  input logic         mem_req,
  input logic         mem_we,
  input logic         mem_ack,
  input logic [W-1:0] mem_addr,
  input logic [W-1:0] mem_wdata,
  input logic         src_hack,
  input logic         dst_hack,
  input logic         gen,
  input logic         chen,
  input logic [4:0]   raw
);
  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
  // R2
  start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chen) |-> $past(gen));
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chen |-> !mem_req);
  // R5
  done_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw[1]) |-> !chen);
  // R10
  err_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw[2]) |-> !chen && !mem_req);
  // R7
  src_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_hack |-> $past(mem_req && mem_ack && !mem_we));
  // R7
  dst_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dst_hack |-> $past(mem_req && mem_ack && mem_we));
endmodule

bind dma_llist_chan dma_llist_chan_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .src_hack(src_hack), .dst_hack(dst_hack),
  .gen(gen), .chen(chen), .raw(raw)
);

// File: tb/sim_dma_llist_chan.sv
module sim_dma_llist_chan;
  logic clk = 0, rst_n = 0;
  logic reg_we = 0; logic [2:0] reg_addr = 0; logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata, mem_addr, mem_wdata;
  logic [31:0] mem_rdata = 0;
  logic mem_req, mem_we, mem_ack = 0, mem_err = 0;
  logic src_hreq = 0, dst_hreq = 0, src_hack, dst_hack;
  logic [31:0] mem [0:255];
  logic [31:0] exp_img [0:255];
  int checks = 0, fails = 0, req_cycles = 0, shack = 0, dhack = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dma_llist_chan u0 (.*);

  always @(posedge clk) begin
    mem_ack <= 1'b0; mem_err <= 1'b0;
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1; mem_err <= mem_addr[31];
      mem_rdata <= mem[mem_addr[9:2]];
      if (mem_we && !mem_addr[31]) mem[mem_addr[9:2]] <= mem_wdata;
    end
    if (mem_req) req_cycles++;
    if (src_hack) shack++;
    if (dst_hack) dhack++;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 600; i++) begin
      rd(3'd1, v);
      if (v == 0) break;
    end
  endtask

  function automatic logic [31:0] stepv(input logic [31:0] a, input int m);
    return (m == 0) ? a + 4 : (m == 1) ? a - 4 : a;
  endfunction

  task automatic setup_mem();
    for (int i = 0; i < 256; i++) mem[i] = (i >= 64 && i < 128) ? 32'hA000_0000 + i : 32'h0;
  endtask

  task automatic run_chain(input int nb, input int len, input int sm, input int dm);
    logic [31:0] d, v, s;
    setup_mem();
    for (int b = 0; b < nb; b++) begin
      mem[4*b]   = 32'h180 + 32'h20 * b;
      mem[4*b+1] = 32'h0000_0380 + b;
      mem[4*b+2] = (b < nb - 1) ? 32'h10 * (b + 1) : 32'h0;
      mem[4*b+3] = len | (sm << 16) | (dm << 18);
    end
    for (int i = 0; i < 256; i++) exp_img[i] = mem[i];
    d = 32'h300;
    for (int b = 0; b < nb; b++) begin
      s = 32'h180 + 32'h20 * b;
      for (int k = 0; k < len; k++) begin
        exp_img[d[9:2]] = mem[s[9:2]];
        s = stepv(s, sm); d = stepv(d, dm);
      end
    end
    wr(3'd6, 32'h1F); wr(3'd2, 32'h0); wr(3'd3, 32'h300); wr(3'd0, 32'h1); wr(3'd1, 32'h1);
    wait_idle();
    repeat (2) @(negedge clk);
    begin
      int bad = -1;
      for (int i = 0; i < 256; i++) if (bad < 0 && mem[i] !== exp_img[i]) bad = i;
      chk(bad < 0, $sformatf("R4/R6 image nb=%0d len=%0d sm=%0d dm=%0d word %0d", nb, len, sm, dm, bad),
          (bad < 0) ? 32'h0 : mem[bad], (bad < 0) ? 32'h0 : exp_img[bad]);
    end
    rd(3'd3, v); chk(v == d, "R4 running destination register", v, d);
    rd(3'd5, v); chk(v[2:0] == 3'b011, "R5 block/transfer done status", v, 32'h3);
  endtask

  initial begin
    logic [31:0] v;
    int base;
    setup_mem();
    repeat (3) @(negedge clk); rst_n = 1;
    // R1
    rd(3'd1, v); chk(v == 0, "R1 channel enable after reset", v, 0);
    rd(3'd5, v); chk(v == 0, "R1 status after reset", v, 0);
    rd(3'd3, v); chk(v == 0, "R1 destination after reset", v, 0);
    chk(mem_req == 0, "R1 mem_req after reset", mem_req, 0);
    // R2: enable write ignored without global enable
    base = req_cycles;
    wr(3'd2, 32'h0); wr(3'd1, 32'h1); repeat (10) @(negedge clk);
    rd(3'd1, v); chk(v == 0, "R2 enable ignored while global off", v, 0);
    chk(req_cycles == base, "R2 no request while global off", req_cycles, base);
    // R3 R4 R5 R6 sweep
    for (int nb = 1; nb <= 3; nb++)
      for (int len = 0; len <= 3; len++)
        for (int sm = 0; sm <= 2; sm++)
          for (int dm = 0; dm <= 2; dm++)
            run_chain(nb, len, sm, dm);
    // R9 clear
    wr(3'd6, 32'h1F); rd(3'd5, v); chk(v == 0, "R9 status cleared", v, 0);
    // R7 hardware-paced source peripheral
    setup_mem();
    mem[0] = 32'h100; mem[1] = 0; mem[2] = 0; mem[3] = 3 | (1 << 20);
    wr(3'd4, 32'h0); wr(3'd3, 32'h300); wr(3'd1, 32'h1);
    repeat (30) @(negedge clk);
    rd(3'd5, v); chk(v[3] == 0, "R7 source waits for hardware request", v, 0);
    chk(mem[192] == 0, "R7 no data before request", mem[192], 0);
    base = shack;
    src_hreq = 1; wait_idle(); src_hreq = 0;
    chk(shack - base == 3, "R7 source acknowledge pulses", shack - base, 3);
    chk(dhack == 0, "R7 memory destination gets no acknowledge", dhack, 0);
    rd(3'd5, v); chk(v[3] == 1 && v[4] == 0, "R9 source transaction flag only", v, 32'h8);
    chk(mem[194] == 32'hA000_0042, "R7 third word moved", mem[194], 32'hA000_0042);
    // R8 software-paced source
    setup_mem();
    mem[0] = 32'h100; mem[1] = 0; mem[2] = 0; mem[3] = 2 | (1 << 20);
    wr(3'd6, 32'h1F); wr(3'd4, 32'h1); wr(3'd3, 32'h300); wr(3'd1, 32'h1);
    base = shack;
    repeat (20) @(negedge clk);
    chk(mem[192] == 0, "R8 stalls without software request", mem[192], 0);
    wr(3'd7, 32'h1); repeat (20) @(negedge clk);
    chk(mem[192] == 32'hA000_0040 && mem[193] == 0, "R8 one word per request", mem[193], 0);
    rd(3'd1, v); chk(v == 1, "R8 still enabled mid-block", v, 1);
    wr(3'd7, 32'h1); wait_idle();
    chk(mem[193] == 32'hA000_0041, "R8 second word after second request", mem[193], 32'hA000_0041);
    chk(shack == base, "R8 no acknowledge in software mode", shack, base);
    // R10 error response
    setup_mem();
    mem[0] = 32'h8000_0000; mem[1] = 0; mem[2] = 0; mem[3] = 2;
    wr(3'd4, 32'h0); wr(3'd6, 32'h1F); wr(3'd3, 32'h300); wr(3'd1, 32'h1);
    wait_idle(); repeat (3) @(negedge clk);
    rd(3'd5, v); chk(v[2:0] == 3'b100, "R10 error flag without done", v, 32'h4);
    rd(3'd1, v); chk(v == 0, "R10 enable cleared", v, 0);
    chk(mem_req == 0, "R10 request dropped", mem_req, 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1500000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule